// File: doc/BRIEF.md
# CPU processing state controller

This block keeps track of which top-level processing state a small CPU core is in. There are five states: reset, exception handling, program execution, bus released and program stop. The block takes an active-low reset pin, a watchdog overflow pulse, exception requests from interrupt, trap and trace sources, a bus request from another bus master, a sleep strobe and a hardware standby level. From these it drives the interrupt mask, the bus grant and the halt enable for the core.

The exception-vector fetch is the only data-carrying exchange. It uses a valid/ready pair. `vec_req` is the valid, `vec_idx` is the payload and `vec_done` is the ready. While `vec_req` is high and `vec_done` is low, the block is back-pressured. It then stays in exception handling and holds `vec_idx` unchanged. The transfer completes on the clock edge where both are high, and program execution begins on the following cycle. All other pins are plain levels or single-cycle strobes.

At most one transition is taken per clock. Priority runs from the reset pin, to watchdog overflow, to a pending exception, to a bus request, and last to sleep or standby.

Top module: `cpu_state_ctl`

## Requirements
- R1: `state_oh` is one-hot in every cycle, with bit 0 for reset, bit 1 for exception handling, bit 2 for program execution, bit 3 for bus released and bit 4 for program stop.
- R2: While `rst_pin_n` is low, the state is reset, asynchronously and from any state. In reset, `int_mask` and `cpu_halt` are 1, and `bus_grant` and `vec_req` are 0.
- R3: The reset state is left only at the first clock edge that samples `rst_pin_n` high, and never while it is held low. The next state is exception handling with `vec_idx` = 0 (the reset vector).
- R4: A `wdt_ovf` pulse moves the block to the reset state at the next edge from any state, and it outranks every other request except the reset pin.
- R5: In exception handling, `vec_req` is 1, `int_mask` is 1 and `vec_idx` stays stable. The block moves to program execution at the edge where `vec_done` is 1.
- R6: In program execution, an exception request moves the block to exception handling. Interrupt beats trap, and trap beats trace, with vector indices 2, 3 and 1 respectively. An exception outranks a bus request and sleep or standby.
- R7: A bus request is granted from program execution only in a cycle where `insn_bound` is 1. In bus released, `bus_grant` and `cpu_halt` are 1 for as long as `bus_req` stays high. When it drops, the block returns to program execution at the next edge.
- R8: In program execution, with no exception and no granted bus request, `sleep_stb` or `standby_in` moves the block to program stop, where `cpu_halt` is 1.
- R9: A stop entered by sleep exits on `irq_req` to exception handling with `vec_idx` = 2. A stop during which standby was asserted stays put while `standby_in` is high, ignores interrupts meanwhile, and exits when it drops to exception handling with `vec_idx` = 4.
- R10: Exception requests, sleep and standby have no effect in exception handling or in bus released. The state stays put until the handshake completes or the bus request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous assert |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_req | input | 1 | Unmasked interrupt request |
| trace_req | input | 1 | Trace exception request |
| trap_req | input | 1 | Trap exception request |
| bus_req | input | 1 | Bus request from another master |
| insn_bound | input | 1 | Instruction boundary strobe |
| sleep_stb | input | 1 | Sleep instruction executed |
| standby_in | input | 1 | Hardware standby level |
| vec_done | input | 1 | Vector fetch ready/complete |
| state_oh | output | 5 | One-hot processing state |
| int_mask | output | 1 | All interrupts masked |
| vec_req | output | 1 | Vector fetch valid |
| vec_idx | output | 3 | Vector index |
| bus_grant | output | 1 | Bus released to other master |
| cpu_halt | output | 1 | CPU halt enable |

## Verification
Every output is a decode of the registered state, so a wrong state or a wrong transition shows at the ports at the very next sampling point after the faulty edge. It appears as a wrong `state_oh` bit, a misplaced grant, halt or mask, or a wrong `vec_idx` while `vec_req` is high. A lost stop cause only shows later, when standby drops and the block fails to wake with vector 4, or when it wrongly wakes on an interrupt while still in standby.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;
  localparam int NUM_ST = 5;
  localparam int VEC_W  = 3;

  typedef enum logic [NUM_ST-1:0] {
    ST_RESET  = 5'b00001,
    ST_EXC    = 5'b00010,
    ST_EXEC   = 5'b00100,
    ST_BUSREL = 5'b01000,
    ST_STOP   = 5'b10000
  } proc_state_e;

  localparam logic [VEC_W-1:0] VEC_RST   = 3'd0;
  localparam logic [VEC_W-1:0] VEC_TRACE = 3'd1;
  localparam logic [VEC_W-1:0] VEC_IRQ   = 3'd2;
  localparam logic [VEC_W-1:0] VEC_TRAP  = 3'd3;
  localparam logic [VEC_W-1:0] VEC_STBY  = 3'd4;
endpackage

// File: rtl/cpu_state_next.sv
module cpu_state_next
  import cpu_state_pkg::*;
(
  input  proc_state_e      cur,
  input  logic             stby_cause,
  input  logic             wdt_ovf,
  input  logic             irq_req,
  input  logic             trace_req,
  input  logic             trap_req,
  input  logic             bus_req,
  input  logic             insn_bound,
  input  logic             sleep_stb,
  input  logic             standby_in,
  input  logic             vec_done,
  output proc_state_e      nxt,
  output logic             load_vec,
  output logic [VEC_W-1:0] nxt_vec,
  output logic             nxt_cause
);
  logic             exc_any;
  logic [VEC_W-1:0] exc_vec;

  // interrupt > trap > trace
  always_comb begin
    exc_any = irq_req | trap_req | trace_req;
    if (irq_req)       exc_vec = VEC_IRQ;
    else if (trap_req) exc_vec = VEC_TRAP;
    else               exc_vec = VEC_TRACE;
  end

  always_comb begin
    nxt       = cur;
    load_vec  = 1'b0;
    nxt_vec   = VEC_RST;
    nxt_cause = stby_cause;
    if (wdt_ovf) begin
      nxt       = ST_RESET;
      nxt_cause = 1'b0;
    end else begin
      case (cur)
        ST_RESET: begin
          nxt      = ST_EXC;
          load_vec = 1'b1;
          nxt_vec  = VEC_RST;
        end
        ST_EXC: begin
          if (vec_done) nxt = ST_EXEC;
        end
        ST_EXEC: begin
          if (exc_any) begin
            nxt      = ST_EXC;
            load_vec = 1'b1;
            nxt_vec  = exc_vec;
          end else if (bus_req && insn_bound) begin
            nxt = ST_BUSREL;
          end else if (sleep_stb || standby_in) begin
            nxt       = ST_STOP;
            nxt_cause = standby_in;
          end
        end
        ST_BUSREL: begin
          if (!bus_req) nxt = ST_EXEC;
        end
        ST_STOP: begin
          nxt_cause = stby_cause | standby_in;
          if (standby_in) begin
            nxt = ST_STOP;
          end else if (stby_cause) begin
            nxt       = ST_EXC;
            load_vec  = 1'b1;
            nxt_vec   = VEC_STBY;
            nxt_cause = 1'b0;
          end else if (irq_req) begin
            nxt      = ST_EXC;
            load_vec = 1'b1;
            nxt_vec  = VEC_IRQ;
          end
        end
        default: nxt = ST_RESET;
      endcase
    end
  end
endmodule

// File: rtl/cpu_state_reg.sv
module cpu_state_reg
  import cpu_state_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  proc_state_e      nxt,
  input  logic             load_vec,
  input  logic [VEC_W-1:0] nxt_vec,
  input  logic             nxt_cause,
  input  logic             vec_done,
  input  logic             wdt_ovf,
  output proc_state_e      cur,
  output logic [VEC_W-1:0] vec_q,
  output logic             stby_cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= ST_RESET;
      vec_q      <= VEC_RST;
      stby_cause <= 1'b0;
    end else begin
      cur        <= nxt;
      stby_cause <= nxt_cause;
      if (load_vec) vec_q <= nxt_vec;
    end
  end

  assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cur) == 1);

  // back-pressured vector fetch keeps its payload (R5)
  assert_vec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_EXC && !vec_done && !wdt_ovf) |=> (cur == ST_EXC && $stable(vec_q)));
endmodule

// File: rtl/cpu_state_ctl.sv
module cpu_state_ctl
  import cpu_state_pkg::*;
(
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              wdt_ovf,
  input  logic              irq_req,
  input  logic              trace_req,
  input  logic              trap_req,
  input  logic              bus_req,
  input  logic              insn_bound,
  input  logic              sleep_stb,
  input  logic              standby_in,
  input  logic              vec_done,
  output logic [NUM_ST-1:0] state_oh,
  output logic              int_mask,
  output logic              vec_req,
  output logic [VEC_W-1:0]  vec_idx,
  output logic              bus_grant,
  output logic              cpu_halt
);
  proc_state_e      cur, nxt;
  logic             load_vec, nxt_cause, stby_cause;
  logic [VEC_W-1:0] nxt_vec, vec_q;

  cpu_state_next u_next (
    .cur        (cur),
    .stby_cause (stby_cause),
    .wdt_ovf    (wdt_ovf),
    .irq_req    (irq_req),
    .trace_req  (trace_req),
    .trap_req   (trap_req),
    .bus_req    (bus_req),
    .insn_bound (insn_bound),
    .sleep_stb  (sleep_stb),
    .standby_in (standby_in),
    .vec_done   (vec_done),
    .nxt        (nxt),
    .load_vec   (load_vec),
    .nxt_vec    (nxt_vec),
    .nxt_cause  (nxt_cause)
  );

  cpu_state_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_pin_n),
    .nxt        (nxt),
    .load_vec   (load_vec),
    .nxt_vec    (nxt_vec),
    .nxt_cause  (nxt_cause),
    .vec_done   (vec_done),
    .wdt_ovf    (wdt_ovf),
    .cur        (cur),
    .vec_q      (vec_q),
    .stby_cause (stby_cause)
  );

  always_comb begin
    state_oh  = cur;
    int_mask  = (cur == ST_RESET) || (cur == ST_EXC);
    vec_req   = (cur == ST_EXC);
    vec_idx   = vec_q;
    bus_grant = (cur == ST_BUSREL);
    cpu_halt  = (cur == ST_RESET) || (cur == ST_BUSREL) || (cur == ST_STOP);
  end

  assert_reset_masked_R2: assert property (@(posedge clk) disable iff (!rst_pin_n)
    state_oh[0] |-> (int_mask && cpu_halt && !bus_grant && !vec_req));

  assert_reset_exit_R3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (state_oh[0] && !wdt_ovf) |=> (vec_req && vec_idx == VEC_RST));

  assert_wdt_reset_R4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    wdt_ovf |=> state_oh[0]);

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (bus_grant && bus_req && !wdt_ovf) |=> (bus_grant && cpu_halt));

  assert_grant_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (state_oh[2] && !insn_bound) |=> !bus_grant);

  assert_standby_stays_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (state_oh[4] && standby_in && !wdt_ovf) |=> state_oh[4]);
endmodule

// File: tb/cpu_state_ctl_bench.sv
module cpu_state_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_pin_n, wdt_ovf, irq_req, trace_req, trap_req, bus_req;
  logic       insn_bound, sleep_stb, standby_in, vec_done;
  logic [4:0] state_oh;
  logic       int_mask, vec_req, bus_grant, cpu_halt;
  logic [2:0] vec_idx;

  int errors = 0;
  int checks = 0;

  localparam logic [4:0] S_RST = 5'b00001, S_EXC = 5'b00010, S_EXE = 5'b00100,
                         S_BUS = 5'b01000, S_STP = 5'b10000;

  logic [4:0] m_st;
  logic [2:0] m_vec;
  logic       m_cause;
  string      m_tag;

  always #5 clk = ~clk;

  cpu_state_ctl u_cpu_state_ctl (
    .clk(clk), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf), .irq_req(irq_req),
    .trace_req(trace_req), .trap_req(trap_req), .bus_req(bus_req),
    .insn_bound(insn_bound), .sleep_stb(sleep_stb), .standby_in(standby_in),
    .vec_done(vec_done), .state_oh(state_oh), .int_mask(int_mask),
    .vec_req(vec_req), .vec_idx(vec_idx), .bus_grant(bus_grant), .cpu_halt(cpu_halt)
  );

  task automatic chk(input string tag, input string what, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, got, exp);
    end
  endtask

  // reference transition from the requirements
  function automatic void model_step();
    logic [4:0] n;
    n = m_st;
    if (!rst_pin_n) begin
      n = S_RST; m_vec = 3'd0; m_cause = 1'b0; m_tag = "R2";
    end else if (wdt_ovf) begin
      n = S_RST; m_cause = 1'b0; m_tag = "R4";
    end else begin
      m_tag = "R1";
      case (m_st)
        S_RST: begin n = S_EXC; m_vec = 3'd0; m_tag = "R3"; end
        S_EXC: begin
          if (vec_done) begin n = S_EXE; m_tag = "R5"; end
          else m_tag = "R10";
        end
        S_EXE: begin
          if (irq_req)        begin n = S_EXC; m_vec = 3'd2; m_tag = "R6"; end
          else if (trap_req)  begin n = S_EXC; m_vec = 3'd3; m_tag = "R6"; end
          else if (trace_req) begin n = S_EXC; m_vec = 3'd1; m_tag = "R6"; end
          else if (bus_req && insn_bound) begin n = S_BUS; m_tag = "R7"; end
          else if (sleep_stb || standby_in) begin n = S_STP; m_cause = standby_in; m_tag = "R8"; end
        end
        S_BUS: begin
          if (!bus_req) n = S_EXE;
          m_tag = (irq_req || trap_req || sleep_stb) ? "R10" : "R7";
        end
        S_STP: begin
          m_tag = "R9";
          if (standby_in) m_cause = 1'b1;
          else if (m_cause) begin n = S_EXC; m_vec = 3'd4; m_cause = 1'b0; end
          else if (irq_req) begin n = S_EXC; m_vec = 3'd2; end
        end
        default: n = S_RST;
      endcase
    end
    m_st = n;
  endfunction

  task automatic check_all();
    chk("R1", "onehot", {4'd0, $countones(state_oh) == 1}, 5'd1);
    chk(m_tag, "state", state_oh, m_st);
    chk(m_st == S_RST ? "R2" : "R5", "int_mask", {4'd0, int_mask},
        {4'd0, (m_st == S_RST) || (m_st == S_EXC)});
    chk("R5", "vec_req", {4'd0, vec_req}, {4'd0, m_st == S_EXC});
    if (m_st == S_EXC) chk(m_tag == "R9" ? "R9" : "R6", "vec_idx", {2'd0, vec_idx}, {2'd0, m_vec});
    chk("R7", "bus_grant", {4'd0, bus_grant}, {4'd0, m_st == S_BUS});
    chk("R8", "cpu_halt", {4'd0, cpu_halt},
        {4'd0, (m_st == S_RST) || (m_st == S_BUS) || (m_st == S_STP)});
  endtask

  task automatic idle_inputs();
    wdt_ovf = 0; irq_req = 0; trace_req = 0; trap_req = 0;
    insn_bound = 0; sleep_stb = 0; vec_done = 0;
  endtask

  // drive at negedge, update model, check at the following negedge
  task automatic step();
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    rst_pin_n = 0; bus_req = 0; standby_in = 0;
    idle_inputs();
    m_st = S_RST; m_vec = 3'd0; m_cause = 1'b0; m_tag = "R2";
    @(negedge clk);
    // directed: pin held low keeps reset (R3)
    for (int i = 0; i < 3; i++) begin
      irq_req = 1; step();
      chk("R3", "held low stays reset", state_oh, S_RST);
    end
    rst_pin_n = 1; idle_inputs(); step();       // -> EXC, vector 0 (R3)
    vec_done = 1; step();                        // -> EXEC (R5)
    idle_inputs(); bus_req = 1; step();          // no boundary: stays EXEC (R7)
    insn_bound = 1; step();                      // -> BUSREL (R7)
    insn_bound = 0; irq_req = 1; step();         // ignored in BUSREL (R10)
    irq_req = 0; bus_req = 0; step();            // -> EXEC (R7)
    standby_in = 1; step();                      // -> STOP (R8)
    irq_req = 1; step();                         // ignored under standby (R9)
    irq_req = 0; standby_in = 0; step();         // -> EXC vector 4 (R9)
    wdt_ovf = 1; vec_done = 1; step();           // watchdog wins (R4)
    idle_inputs(); step();
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      rst_pin_n  = ($urandom % 80) != 0;
      wdt_ovf    = ($urandom % 60) == 0;
      irq_req    = ($urandom % 10) == 0;
      trap_req   = ($urandom % 16) == 0;
      trace_req  = ($urandom % 16) == 0;
      insn_bound = ($urandom % 2) == 0;
      sleep_stb  = ($urandom % 12) == 0;
      vec_done   = ($urandom % 3) == 0;
      if (($urandom % 6) == 0)  bus_req = ~bus_req;
      if (($urandom % 30) == 0) standby_in = ~standby_in;
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule